// File: doc/BRIEF.md
# Serial EEPROM Byte-Read Sequencer

This block is a bus master that fetches a run of bytes from a small serial EEPROM, for example a stored hardware address that the chip needs after power-up. A host supplies a start address, a byte count and a mode bit, then pulses `start`. The block drives the memory's chip select, serial clock and serial data line, and reads the memory's serial output. Each byte it fetches comes out on `rdData` with a one-cycle `rdValid` strobe. A one-cycle `done` pulse marks the end of the request.

The block makes one complete chip-select transaction per byte. Each transaction holds the read opcode, an 8-bit address and eight captured data bits. Between transactions the block steps the address by one. A second mode reads the memory's status register instead: a different opcode, no address, and exactly one byte. The first request after reset begins with a short wake-up preamble, which is two clock pulses sent with chip select inactive. Each serial-clock half-period lasts `HALF_DIV` system clocks. To meet a half-period t, set `HALF_DIV` to the system clock frequency times t.

Top module: `eeprom_reader`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `spiCsN` is 1, and `spiSck`, `spiMosi`, `busy`, `done` and `rdValid` are 0. The next accepted request starts with the preamble.
- R2: Every serial-clock half-period lasts exactly `HALF_DIV` system clocks. When no request is in progress, `spiCsN` is 1 and `spiSck` is 0.
- R3: The first accepted request after reset first gives two `spiSck` pulses (high half, then low half, twice) with `spiCsN` held at 1. No later request repeats the preamble.
- R4: In data mode (`statusRead`=0), each transaction works as follows. `spiCsN` goes to 0 for one low-clock half with the first bit already on `spiMosi`. Next come 24 clock periods, each a high half followed by a low half. Over the first 16 periods, `spiMosi` carries opcode 0x03 and then the byte address, both MSB first. `spiMosi` changes only at falling clock edges and is 0 during the last 8 periods.
- R5: `spiMiso` is sampled once per capture period, at the system edge that ends its high half. The first sample is the MSB. The assembled byte appears on `rdData`, with `rdValid` high for one cycle, in the first cycle after `spiCsN` returns to 1.
- R6: A data-mode request for N bytes runs N transactions. Each transaction is followed by one half-period with `spiCsN`=1 and `spiSck`=0. The address rises by one per byte and wraps from 0xFF to 0x00. N may be as large as 256.
- R7: In status mode (`statusRead`=1), the block sends opcode 0x05 and then captures 8 bits, with no address. It returns exactly one byte, whatever `byteCount` holds.
- R8: `busy` is 1 from the cycle after an accepted `start` until the final gap half ends. In the cycle where `busy` falls, `done` is 1 for exactly one cycle.
- R9: A `start` that arrives while `busy` is 1 is ignored. The running request keeps its address, count and mode.
- R10: A data-mode `start` with `byteCount`=0 gives a `done` pulse in the next cycle. It causes no bus activity, `busy` stays 0, and the preamble stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, accepted only when idle |
| statusRead | input | 1 | 1 = read the status register, 0 = read data bytes |
| startAddr | input | 8 | First byte address |
| byteCount | input | 9 | Number of bytes to read (0 to 256) |
| spiCsN | output | 1 | Memory chip select, active low |
| spiSck | output | 1 | Serial clock to the memory |
| spiMosi | output | 1 | Serial data to the memory |
| spiMiso | input | 1 | Serial data from the memory |
| rdData | output | 8 | Last byte read |
| rdValid | output | 1 | One-cycle strobe for `rdData` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The bench targets the following corner cases:
- **Address wrap across 0xFF.** A design that carried into a ninth address bit, or that stopped early, would send the wrong address on the wire and return the wrong bytes.
- **Full 256-byte request.** This case exposes a count register one bit too narrow.
- **Zero-length request.** A faulty block might start a transaction or consume the preamble.
- **Status read with a nonzero count.** A faulty block might emit more than one byte, or send an address after opcode 0x05.
- **Preamble only once after reset.** A request cut off by reset shows whether the preamble flag is restored.
- **Start pulse in mid-transfer.** A design that honoured it would restart with the wrong opcode and address.

A behavioural memory model answers on the serial lines. It compares every cycle of chip select, clock, data-out and the strobes against a per-cycle expectation.

// File: rtl/eeprom_reader_pkg.sv
package eeprom_reader_pkg;

  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OP_READ   = 8'h03;
  localparam logic [OP_W-1:0] OP_STATUS = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHost;   // latch address, count and mode
    logic loadShift;  // load opcode (and address) into the output shifter
    logic shiftOut;   // advance the output shifter at a falling clock edge
    logic capture;    // sample serial input at a falling clock edge
    logic emit;       // present a byte, step address, decrement count
  } dpCtrl_t;

endpackage

// File: rtl/eeprom_reader_dp.sv
module eeprom_reader_dp
  import eeprom_reader_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [CNT_W-1:0]  hostCount,
  input  logic              hostStatus,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              statusSel,
  output logic              noneLeft,
  output logic              emptyReq
);

  localparam int SR_W = OP_W + ADDR_W;

  logic [SR_W-1:0]   outSr;
  logic [DATA_W-1:0] inSr;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  bytesLeft;
  logic              modeNow;
  logic [ADDR_W-1:0] addrNow;

  // on the cycle the host values are latched, use them directly
  assign modeNow  = ctrl.loadHost ? hostStatus : statusSel;
  assign addrNow  = ctrl.loadHost ? hostAddr   : curAddr;
  assign mosi     = outSr[SR_W-1];
  assign noneLeft = (bytesLeft == '0);
  assign emptyReq = !hostStatus && (hostCount == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      outSr     <= '0;
      inSr      <= '0;
      curAddr   <= '0;
      bytesLeft <= '0;
      statusSel <= 1'b0;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      rdValid <= ctrl.emit;
      if (ctrl.loadHost) begin
        curAddr   <= hostAddr;
        bytesLeft <= hostStatus ? CNT_W'(1) : hostCount;
        statusSel <= hostStatus;
      end
      if (ctrl.loadShift) begin
        outSr <= modeNow ? {OP_STATUS, ADDR_W'(0)} : {OP_READ, addrNow};
      end else if (ctrl.shiftOut) begin
        outSr <= {outSr[SR_W-2:0], 1'b0};
      end
      if (ctrl.capture) begin
        inSr <= {inSr[DATA_W-2:0], miso};
      end
      if (ctrl.emit) begin
        rdData    <= inSr;
        curAddr   <= curAddr + 1'b1;
        bytesLeft <= bytesLeft - 1'b1;
      end
    end
  end

endmodule

// File: rtl/eeprom_reader_ctrl.sv
module eeprom_reader_ctrl
  import eeprom_reader_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    statusSel,
  input  logic    noneLeft,
  input  logic    emptyReq,
  output dpCtrl_t ctrl,
  output logic    csN,
  output logic    sck,
  output logic    busy,
  output logic    done
);

  localparam int DIV_W     = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int FULL_BITS = OP_W + ADDR_W + DATA_W;
  localparam int STAT_BITS = OP_W + DATA_W;
  localparam int BIT_W     = $clog2(FULL_BITS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  seqState_t        state, nxt;
  logic [DIV_W-1:0] divCnt;
  logic [1:0]       preCnt, nxtPre;
  logic [BIT_W-1:0] bitIdx, lastBit, firstIn;
  logic             prePending;
  logic             tick;
  logic             doneNext;

  assign tick    = (divCnt == DIV_LAST);
  assign lastBit = statusSel ? BIT_W'(STAT_BITS - 1) : BIT_W'(FULL_BITS - 1);
  assign firstIn = statusSel ? BIT_W'(OP_W) : BIT_W'(OP_W + ADDR_W);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    nxt      = state;
    nxtPre   = preCnt;
    ctrl     = '0;
    doneNext = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (emptyReq) begin
            doneNext = 1'b1;
          end else begin
            ctrl.loadHost = 1'b1;
            if (prePending) begin
              nxt    = ST_PRE;
              nxtPre = 2'd0;
            end else begin
              nxt            = ST_SETUP;
              ctrl.loadShift = 1'b1;
            end
          end
        end
      end
      ST_PRE: begin
        if (tick) begin
          if (preCnt == 2'd3) begin
            nxt            = ST_SETUP;
            ctrl.loadShift = 1'b1;
          end else begin
            nxtPre = preCnt + 2'd1;
          end
        end
      end
      ST_SETUP: begin
        if (tick) nxt = ST_HIGH;
      end
      ST_HIGH: begin
        if (tick) begin
          nxt           = ST_LOW;
          ctrl.shiftOut = 1'b1;
          ctrl.capture  = (bitIdx >= firstIn);
        end
      end
      ST_LOW: begin
        if (tick) begin
          if (bitIdx == lastBit) begin
            nxt       = ST_GAP;
            ctrl.emit = 1'b1;
          end else begin
            nxt = ST_HIGH;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (noneLeft) begin
            nxt      = ST_IDLE;
            doneNext = 1'b1;
          end else begin
            nxt            = ST_SETUP;
            ctrl.loadShift = 1'b1;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      divCnt     <= '0;
      preCnt     <= '0;
      bitIdx     <= '0;
      prePending <= 1'b1;
      csN        <= 1'b1;
      sck        <= 1'b0;
      done       <= 1'b0;
    end else begin
      state  <= nxt;
      preCnt <= nxtPre;
      done   <= doneNext;
      if (state == ST_IDLE || tick) divCnt <= '0;
      else                          divCnt <= divCnt + 1'b1;
      if (nxt == ST_SETUP)                         bitIdx <= '0;
      else if (state == ST_LOW && nxt == ST_HIGH)  bitIdx <= bitIdx + 1'b1;
      if (nxt == ST_PRE) prePending <= 1'b0;
      // outputs registered from the next state: no decode glitches
      csN <= !(nxt == ST_SETUP || nxt == ST_HIGH || nxt == ST_LOW);
      sck <= (nxt == ST_HIGH) || (nxt == ST_PRE && !nxtPre[0]);
    end
  end

endmodule

// File: rtl/eeprom_reader.sv
module eeprom_reader
  import eeprom_reader_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              statusRead,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              spiCsN,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              busy,
  output logic              done
);

  dpCtrl_t dpCtrl;
  logic    statusSel;
  logic    noneLeft;
  logic    emptyReq;

  eeprom_reader_ctrl #(
    .HALF_DIV(HALF_DIV),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .statusSel(statusSel),
    .noneLeft (noneLeft),
    .emptyReq (emptyReq),
    .ctrl     (dpCtrl),
    .csN      (spiCsN),
    .sck      (spiSck),
    .busy     (busy),
    .done     (done)
  );

  eeprom_reader_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (dpCtrl),
    .hostAddr  (startAddr),
    .hostCount (byteCount),
    .hostStatus(statusRead),
    .miso      (spiMiso),
    .mosi      (spiMosi),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .statusSel (statusSel),
    .noneLeft  (noneLeft),
    .emptyReq  (emptyReq)
  );

endmodule

// File: rtl/eeprom_reader_chk.sv
module eeprom_reader_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic spiCsN,
  input logic spiSck,
  input logic spiMosi,
  input logic rdValid,
  input logic busy,
  input logic done
);

  // R1: reset leaves the bus and the strobes idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (spiCsN && !spiSck && !spiMosi && !busy && !done && !rdValid));

  // R2: an idle block keeps the bus parked
  a_r2_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (spiCsN && !spiSck));

  // R4: data to the memory never moves while the clock is high
  a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (!spiCsN && spiSck) |-> $stable(spiMosi));

  // R5: a byte is presented exactly as chip select returns high
  a_r5_valid_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $rose(spiCsN));

  // R8: busy falls only together with done, and done lasts one cycle
  a_r8_done_on_busy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a request while busy does not cut the running one short
  a_r9_start_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

endmodule

bind eeprom_reader eeprom_reader_chk i_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .spiCsN (spiCsN),
  .spiSck (spiSck),
  .spiMosi(spiMosi),
  .rdValid(rdValid),
  .busy   (busy),
  .done   (done)
);

// File: tb/test_eeprom_reader.sv
module test_eeprom_reader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WATCHDOG   = 120000;
  localparam logic [7:0] STATUS_VAL = 8'hC6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       statusRead = 1'b0;
  logic [7:0] startAddr = '0;
  logic [8:0] byteCount = '0;
  logic       spiCsN, spiSck, spiMosi;
  logic       spiMiso;
  logic [7:0] rdData;
  logic       rdValid, busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_reader #(.HALF_DIV(HALF)) i_eeprom_reader (
    .clk(clk), .rst(rst), .start(start), .statusRead(statusRead),
    .startAddr(startAddr), .byteCount(byteCount),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .rdData(rdData), .rdValid(rdValid), .busy(busy), .done(done)
  );

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  // ---------------- memory model on the serial lines ----------------
  logic [7:0] romImg [256];
  int         bitCnt = 0;
  logic [7:0] opSh = '0, adSh = '0;
  logic       misoDrv = 1'b0;
  int         preRise = 0;
  assign spiMiso = misoDrv;

  initial begin
    for (int i = 0; i < 256; i++) romImg[i] = 8'(i * 37 + 11) ^ 8'h5C;
  end

  always @(negedge spiCsN) bitCnt = 0;

  always @(posedge spiSck) begin
    if (spiCsN) preRise++;
    else begin
      if (bitCnt < 8)       opSh = {opSh[6:0], spiMosi};
      else if (bitCnt < 16) adSh = {adSh[6:0], spiMosi};
      bitCnt++;
    end
  end

  always @(negedge spiSck) begin
    if (!spiCsN) begin
      if (opSh == 8'h03 && bitCnt >= 16 && bitCnt < 24)
        misoDrv = romImg[adSh][23 - bitCnt];
      else if (opSh == 8'h05 && bitCnt >= 8 && bitCnt < 16)
        misoDrv = STATUS_VAL[15 - bitCnt];
      else
        misoDrv = 1'b0;
    end
  end

  // ---------------- cycle-by-cycle expectation ----------------
  typedef struct packed {
    logic       csN;
    logic       sck;
    logic       mosi;
    logic       dv;
    logic [7:0] data;
    logic       bsy;
    logic       dn;
    logic [3:0] id;
  } expCyc_t;

  expCyc_t expQ[$];
  bit      modelPre = 1'b1;

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd10: return "R10";
      default: return "R2";
    endcase
  endfunction

  function automatic void pushHalf(input logic cs, input logic sk, input logic mo,
                                   input logic [3:0] id);
    for (int c = 0; c < HALF; c++)
      expQ.push_back('{csN: cs, sck: sk, mosi: mo, dv: 1'b0, data: 8'h00,
                       bsy: 1'b1, dn: 1'b0, id: id});
  endfunction

  function automatic void planRequest(input logic [7:0] a, input int n, input logic st);
    int         nb;
    int         tot;
    logic [7:0] addr;
    logic [23:0] ob;
    logic [3:0] tag;
    if (!st && n == 0) begin
      // R10: immediate done, no bus activity
      expQ.push_back('{csN: 1, sck: 0, mosi: 0, dv: 0, data: 0, bsy: 0, dn: 1, id: 4'd10});
      return;
    end
    if (modelPre) begin
      pushHalf(1, 1, 0, 4'd3); pushHalf(1, 0, 0, 4'd3);
      pushHalf(1, 1, 0, 4'd3); pushHalf(1, 0, 0, 4'd3);
      modelPre = 1'b0;
    end
    nb   = st ? 1 : n;
    tot  = st ? 16 : 24;
    tag  = st ? 4'd7 : 4'd4;
    addr = a;
    for (int b = 0; b < nb; b++) begin
      ob = st ? {8'h05, 16'h0000} : {8'h03, addr, 8'h00};
      pushHalf(0, 0, ob[23], tag);
      for (int i = 0; i < tot; i++) begin
        pushHalf(0, 1, ob[23 - i], tag);
        pushHalf(0, 0, (i + 1 < tot) ? ob[22 - i] : 1'b0, tag);
      end
      expQ.push_back('{csN: 1, sck: 0, mosi: 0, dv: 1,
                       data: st ? STATUS_VAL : romImg[addr],
                       bsy: 1, dn: 0, id: 4'd5});
      for (int c = 1; c < HALF; c++)
        expQ.push_back('{csN: 1, sck: 0, mosi: 0, dv: 0, data: 0, bsy: 1, dn: 0, id: 4'd6});
      addr = addr + 8'd1;
    end
    expQ.push_back('{csN: 1, sck: 0, mosi: 0, dv: 0, data: 0, bsy: 0, dn: 1, id: 4'd8});
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expQ.delete();
      modelPre = 1'b1;
    end else if (start && expQ.size() == 0) begin
      planRequest(startAddr, int'(byteCount), statusRead);
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit         armed = 1'b0;
  int         dvSeen = 0;
  logic [7:0] lastData = '0;

  always @(posedge clk) armed <= 1'b1;

  always @(negedge clk) begin
    expCyc_t e;
    logic [5:0] act, want;
    string tag;
    if (armed && !finished) begin
      if (expQ.size() > 0) e = expQ.pop_front();
      else e = '{csN: 1, sck: 0, mosi: 0, dv: 0, data: 0, bsy: 0, dn: 0, id: 4'd1};
      act  = {spiCsN, spiSck, spiMosi, rdValid, busy, done};
      want = {e.csN, e.sck, e.mosi, e.dv, e.bsy, e.dn};
      vectors++;
      if (act !== want || (e.dv && rdData !== e.data)) begin
        fails++;
        tag = (spiSck !== e.sck) ? "R2" : reqName(e.id);
        $display("FAIL %s cycle %0t: {cs,sck,mosi,dv,busy,done,data}=%b/%h expected %b/%h",
                 tag, $time, act, rdData, want, e.data);
      end
      if (rdValid) begin
        dvSeen++;
        lastData = rdData;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [7:0] a, input int n, input logic st);
    @(negedge clk);
    startAddr  = a;
    byteCount  = 9'(n);
    statusRead = st;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle;
    repeat (2) @(negedge clk);
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual %0d expected %0d cycles", WATCHDOG, WATCHDOG);
    finishRun();
  end

  // ---------------- scenarios ----------------
  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    check(spiCsN && !spiSck && !spiMosi && !busy && !done && !rdValid, "R1",
          int'({spiCsN, spiSck, spiMosi, busy, done, rdValid}), 32);

    // R4, R5: two data bytes, first request carries the preamble
    base = dvSeen;
    launch(8'h10, 2, 1'b0); settle();
    check(dvSeen - base == 2, "R4", dvSeen - base, 2);
    check(lastData == romImg[8'h11], "R5", lastData, romImg[8'h11]);

    // R7: status read returns one byte despite a count of five
    base = dvSeen;
    launch(8'h00, 5, 1'b1); settle();
    check(dvSeen - base == 1, "R7", dvSeen - base, 1);
    check(lastData == STATUS_VAL, "R7", lastData, STATUS_VAL);

    // R6: address wraps across the top
    base = dvSeen;
    launch(8'hFE, 3, 1'b0); settle();
    check(dvSeen - base == 3, "R6", dvSeen - base, 3);
    check(lastData == romImg[8'h00], "R6", lastData, romImg[8'h00]);

    // R10: zero count gives done only
    base = dvSeen;
    launch(8'h33, 0, 1'b0); settle();
    check(dvSeen - base == 0, "R10", dvSeen - base, 0);
    check(preRise == 2, "R3", preRise, 2);

    // R9: start while busy is ignored
    base = dvSeen;
    launch(8'h40, 2, 1'b0);
    repeat (30) @(negedge clk);
    startAddr = 8'h99; byteCount = 9'd7; statusRead = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    settle();
    check(dvSeen - base == 2, "R9", dvSeen - base, 2);
    check(lastData == romImg[8'h41], "R9", lastData, romImg[8'h41]);

    // R1, R3: reset mid-request restores the preamble
    launch(8'h20, 1, 1'b0);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(spiCsN && !spiSck && !busy, "R1", int'({spiCsN, spiSck, busy}), 4);
    base = dvSeen;
    launch(8'h21, 1, 1'b0); settle();
    check(preRise == 4, "R3", preRise, 4);
    check(lastData == romImg[8'h21], "R5", lastData, romImg[8'h21]);

    // R6: full 256-byte sweep
    base = dvSeen;
    launch(8'h00, 256, 1'b0); settle();
    check(dvSeen - base == 256, "R6", dvSeen - base, 256);
    check(lastData == romImg[8'hFF], "R6", lastData, romImg[8'hFF]);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule